// File: doc/BRIEF.md
# Page-Table Cache Invalidation Engine

This block removes stale IO page-table entries from a small translation cache. Software writes a single 64-bit command word that carries how many entries to drop, the physical address of the first one, and a go/busy flag. While busy, a sequencer steps across every cache line, one line per clock. It clears the valid bit of each line whose cached entry address falls inside the requested range. When the walk ends, the busy flag drops. Software polls the same register until busy reads zero, and only then issues the next command.

Ranges longer than the count field can express are covered by back-to-back commands. Each command moves the start address forward by the count of the one before it. The cache lines are loaded through a slot-indexed fill port and observed through a probe port. Entries are given as 8-byte-granular entry indices, that is, physical address bits 41:3.

Top module: `ptc_inval_engine`

## Requirements
- R1: After reset the register reads all zeros (busy bit 0 = 0, error bit 1 = 0) and every cache line is invalid, so every probe misses.
- R2: A write while idle with bit 0 = 1 starts a command. From the next cycle the register reads bit 0 = 1, the count in bits 63:53 and the start entry in bits 41:3 as written, and zeros in bits 52:42 and bit 2.
- R3: A write while idle with bit 0 = 0 stores the count and start fields but does not set busy and invalidates nothing.
- R4: A command clears every valid line whose entry index e satisfies start <= e < start+count. Lines at start-1 and at start+count stay valid.
- R5: A write that arrives while busy is ignored: the fields and the walk are unchanged and bit 1 (error) becomes 1. Bit 1 returns to 0 when a later write is accepted.
- R6: A command with count 0 holds busy for exactly one cycle and changes no line.
- R7: A command with a nonzero count holds busy for exactly LINES cycles (8 by default), then busy reads 0.
- R8: A fill while idle makes the slot valid with the given entry index, and a probe hits when a valid line holds that index. A fill while busy is ignored.
- R9: The largest count, 2047, is honoured in full. A range split into two commands, the second starting at first start + 2047, clears exactly the union of the two ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Command register write strobe |
| reg_wdata | input | 64 | Command word written |
| reg_rdata | output | 64 | Command register read-back value |
| fill_en | input | 1 | Load a cache line |
| fill_slot | input | SLOT_W | Cache line index for the fill |
| fill_entry | input | 39 | Entry index (address bits 41:3) stored on fill |
| probe_entry | input | 39 | Entry index looked up in the cache |
| probe_hit | output | 1 | A valid line holds probe_entry |

## Verification
The hardest case to reach from the ports is a second command or a fill that lands in the middle of a walk. The bench issues the command and, on the very next cycle, drives the conflicting write or fill, so that it arrives while busy is surely 1. It then confirms the outcome through the read-back fields and probes taken after busy falls. The count-limit boundary is reached by placing cached entries at the exact first, last and one-past-last indices of two 2047-entry commands.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   // Command word layout (positions are decoded by software)
   localparam int CMD_W   = 64;
   localparam int CNT_LSB = 53;
   localparam int CNT_W   = 11;
   localparam int ENT_LSB = 3;
   localparam int ENT_W   = 39;
   localparam int GO_BIT  = 0;
   localparam int ERR_BIT = 1;

   typedef struct packed {
      logic [CNT_W-1:0] count;
      logic [ENT_W-1:0] start;
   } ptc_cmd_t;

   function automatic ptc_cmd_t ptc_decode(input logic [CMD_W-1:0] w);
      ptc_cmd_t c;
      c.count = w[CNT_LSB +: CNT_W];
      c.start = w[ENT_LSB +: ENT_W];
      return c;
   endfunction

   function automatic logic [CMD_W-1:0] ptc_encode(input ptc_cmd_t c,
                                                    input logic err,
                                                    input logic busy);
      logic [CMD_W-1:0] w;
      w = '0;
      w[CNT_LSB +: CNT_W] = c.count;
      w[ENT_LSB +: ENT_W] = c.start;
      w[ERR_BIT]          = err;
      w[GO_BIT]           = busy;
      return w;
   endfunction
endpackage

// File: rtl/ptc_cmd_reg.sv
module ptc_cmd_reg
   import ptc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CMD_W-1:0] wr_data,
   input  logic             done,
   output logic             busy,
   output logic             err,
   output ptc_cmd_t         cmd,
   output logic [CMD_W-1:0] rd_data
);
   logic unused_wbits;
   assign unused_wbits = ^{wr_data[CNT_LSB-1:ENT_LSB+ENT_W], wr_data[2:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         err  <= 1'b0;
         cmd  <= '0;
      end else begin
         if (done)
            busy <= 1'b0;
         if (wr_en && busy)
            err <= 1'b1;
         if (wr_en && !busy) begin
            cmd  <= ptc_decode(wr_data);
            err  <= 1'b0;
            busy <= wr_data[GO_BIT];
         end
      end
   end

   assign rd_data = ptc_encode(cmd, err, busy);

   // R5
   busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy && !done) |=> (err && busy && $stable(cmd)));
endmodule

// File: rtl/ptc_walker.sv
module ptc_walker #(
   parameter  int LINES  = 8,
   localparam int SLOT_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              zero_cnt,
   output logic              inv_en,
   output logic [SLOT_W-1:0] inv_idx,
   output logic              done
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(LINES - 1);

   logic [SLOT_W-1:0] cursor;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cursor <= '0;
      else if (!busy || zero_cnt)
         cursor <= '0;
      else
         cursor <= cursor + 1'b1;
   end

   assign inv_en  = busy && !zero_cnt;
   assign inv_idx = cursor;
   assign done    = busy && (zero_cnt || cursor == LAST);

   // R6
   zero_cnt_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && zero_cnt) |=> !busy);
   // R7
   walk_ends_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !zero_cnt && cursor == LAST) |=> !busy);
   // R7
   walk_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !zero_cnt && cursor != LAST) |=> (busy && cursor == $past(cursor) + 1'b1));
endmodule

// File: rtl/ptc_tag_cache.sv
module ptc_tag_cache
   import ptc_pkg::*;
#(
   parameter  int LINES  = 8,
   localparam int SLOT_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              fill_en,
   input  logic [SLOT_W-1:0] fill_slot,
   input  logic [ENT_W-1:0]  fill_entry,
   input  logic              inv_en,
   input  logic [SLOT_W-1:0] inv_idx,
   input  logic [ENT_W-1:0]  rng_start,
   input  logic [CNT_W-1:0]  rng_count,
   input  logic [ENT_W-1:0]  probe_entry,
   output logic              probe_hit
);
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] in_rng;
   logic [LINES-1:0] match;
   logic [ENT_W:0]   rng_end;

   assign rng_end = {1'b0, rng_start} + (ENT_W+1)'(rng_count);

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [ENT_W-1:0] tag_q;

      assign in_rng[g] = ({1'b0, tag_q} >= {1'b0, rng_start}) &&
                         ({1'b0, tag_q} <  rng_end);
      assign match[g]  = valid_q[g] && (tag_q == probe_entry);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            tag_q      <= '0;
         end else if (inv_en && inv_idx == SLOT_W'(g)) begin
            if (in_rng[g])
               valid_q[g] <= 1'b0;
         end else if (fill_en && !busy && fill_slot == SLOT_W'(g)) begin
            valid_q[g] <= 1'b1;
            tag_q      <= fill_entry;
         end
      end
   end

   assign probe_hit = |match;

   // R8
   no_fill_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((valid_q & ~$past(valid_q)) == '0));
   // R4
   range_line_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && in_rng[inv_idx]) |=> !valid_q[$past(inv_idx)]);
   // R4
   outside_line_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && !in_rng[inv_idx] && valid_q[inv_idx]) |=> valid_q[$past(inv_idx)]);
endmodule

// File: rtl/ptc_inval_engine.sv
module ptc_inval_engine
   import ptc_pkg::*;
#(
   parameter  int LINES  = 8,
   localparam int SLOT_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   input  logic              fill_en,
   input  logic [SLOT_W-1:0] fill_slot,
   input  logic [38:0]       fill_entry,
   input  logic [38:0]       probe_entry,
   output logic              probe_hit
);
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("ptc_inval_engine: LINES must be a power of two, at least 2");
   end

   logic              busy;
   logic              err;
   logic              done;
   logic              inv_en;
   logic [SLOT_W-1:0] inv_idx;
   ptc_cmd_t          cmd;

   ptc_cmd_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wr_data (reg_wdata),
      .done    (done),
      .busy    (busy),
      .err     (err),
      .cmd     (cmd),
      .rd_data (reg_rdata)
   );

   ptc_walker #(.LINES(LINES)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .zero_cnt (cmd.count == '0),
      .inv_en   (inv_en),
      .inv_idx  (inv_idx),
      .done     (done)
   );

   ptc_tag_cache #(.LINES(LINES)) u_cache (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy        (busy),
      .fill_en     (fill_en),
      .fill_slot   (fill_slot),
      .fill_entry  (fill_entry),
      .inv_en      (inv_en),
      .inv_idx     (inv_idx),
      .rng_start   (cmd.start),
      .rng_count   (cmd.count),
      .probe_entry (probe_entry),
      .probe_hit   (probe_hit)
   );

   // R2
   go_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy && reg_wdata[0]) |=> reg_rdata[0]);
   // R3
   no_go_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy && !reg_wdata[0]) |=> !reg_rdata[0]);
endmodule

// File: tb/ptc_inval_engine_tb.sv
module ptc_inval_engine_tb;
   localparam int LINES  = 8;
   localparam int SLOT_W = $clog2(LINES);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [63:0]       reg_wdata = '0;
   logic [63:0]       reg_rdata;
   logic              fill_en = 1'b0;
   logic [SLOT_W-1:0] fill_slot = '0;
   logic [38:0]       fill_entry = '0;
   logic [38:0]       probe_entry = '0;
   logic              probe_hit;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   ptc_inval_engine #(.LINES(LINES)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fill_en(fill_en), .fill_slot(fill_slot), .fill_entry(fill_entry),
      .probe_entry(probe_entry), .probe_hit(probe_hit)
   );

   task automatic check(input logic ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic write_cmd(input logic [10:0] cnt, input logic [38:0] ent,
                            input logic go);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_wdata = {cnt, 11'd0, ent, 2'b00, go};
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic fill(input int slot, input logic [38:0] ent);
      @(negedge clk);
      fill_en    = 1'b1;
      fill_slot  = SLOT_W'(slot);
      fill_entry = ent;
      @(negedge clk);
      fill_en    = 1'b0;
   endtask

   task automatic probe(input logic [38:0] ent, input logic exp, input string req);
      probe_entry = ent;
      #1;
      check(probe_hit == exp, req, 64'(probe_hit), 64'(exp));
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 100 && reg_rdata[0]; i++) @(negedge clk);
   endtask

   task automatic load_base(input logic [38:0] base);
      for (int i = 0; i < LINES; i++) fill(i, base + 39'(i));
   endtask

   task automatic t_reset();
      check(reg_rdata == 64'd0, "R1 reset register", reg_rdata, 64'd0);
      probe(39'd0, 1'b0, "R1 reset line invalid");
   endtask

   task automatic t_basic();
      int n;
      load_base(39'd100);
      write_cmd(11'd3, 39'd102, 1'b1);
      check(reg_rdata[0] == 1'b1, "R2 busy set", 64'(reg_rdata[0]), 64'd1);
      check(reg_rdata[63:53] == 11'd3, "R2 count field", 64'(reg_rdata[63:53]), 64'd3);
      check(reg_rdata[41:3] == 39'd102, "R2 start field", 64'(reg_rdata[41:3]), 64'd102);
      check({reg_rdata[52:42], reg_rdata[2]} == '0, "R2 zero bits", 64'({reg_rdata[52:42], reg_rdata[2]}), 64'd0);
      n = 0;
      while (reg_rdata[0] && n < 100) begin
         n++;
         @(negedge clk);
      end
      check(n == LINES, "R7 busy length", 64'(n), 64'(LINES));
      probe(39'd101, 1'b1, "R4 below range kept");
      probe(39'd102, 1'b0, "R4 start cleared");
      probe(39'd104, 1'b0, "R4 last cleared");
      probe(39'd105, 1'b1, "R4 end kept");
   endtask

   task automatic t_zero();
      load_base(39'd200);
      write_cmd(11'd0, 39'd200, 1'b1);
      check(reg_rdata[0] == 1'b1, "R6 busy one cycle", 64'(reg_rdata[0]), 64'd1);
      @(negedge clk);
      check(reg_rdata[0] == 1'b0, "R6 busy cleared", 64'(reg_rdata[0]), 64'd0);
      probe(39'd200, 1'b1, "R6 no invalidation");
   endtask

   task automatic t_nogo();
      load_base(39'd300);
      write_cmd(11'd8, 39'd300, 1'b0);
      check(reg_rdata[0] == 1'b0, "R3 not busy", 64'(reg_rdata[0]), 64'd0);
      check(reg_rdata[41:3] == 39'd300, "R3 start stored", 64'(reg_rdata[41:3]), 64'd300);
      repeat (LINES + 2) @(negedge clk);
      probe(39'd300, 1'b1, "R3 nothing invalidated");
   endtask

   task automatic t_busywr();
      load_base(39'd400);
      write_cmd(11'd2, 39'd400, 1'b1);
      write_cmd(11'd8, 39'd400, 1'b1);
      check(reg_rdata[63:53] == 11'd2, "R5 count kept", 64'(reg_rdata[63:53]), 64'd2);
      check(reg_rdata[1] == 1'b1, "R5 error set", 64'(reg_rdata[1]), 64'd1);
      wait_idle();
      probe(39'd401, 1'b0, "R5 first cmd done");
      probe(39'd402, 1'b1, "R5 second cmd ignored");
      write_cmd(11'd0, 39'd0, 1'b1);
      check(reg_rdata[1] == 1'b0, "R5 error cleared", 64'(reg_rdata[1]), 64'd0);
      wait_idle();
   endtask

   task automatic t_fillbusy();
      load_base(39'd500);
      write_cmd(11'd1, 39'd500, 1'b1);
      fill(7, 39'd900);
      wait_idle();
      probe(39'd900, 1'b0, "R8 fill while busy ignored");
      probe(39'd507, 1'b1, "R8 line kept");
      probe(39'd500, 1'b0, "R8 range cleared");
   endtask

   task automatic t_split();
      fill(0, 39'd4999); fill(1, 39'd5000); fill(2, 39'd7046); fill(3, 39'd7047);
      fill(4, 39'd9093); fill(5, 39'd9094); fill(6, 39'd6000); fill(7, 39'd100);
      write_cmd(11'd2047, 39'd5000, 1'b1);
      wait_idle();
      probe(39'd7046, 1'b0, "R9 max count last entry");
      probe(39'd7047, 1'b1, "R9 max count end kept");
      write_cmd(11'd2047, 39'd7047, 1'b1);
      wait_idle();
      probe(39'd4999, 1'b1, "R9 below split kept");
      probe(39'd5000, 1'b0, "R9 first start");
      probe(39'd6000, 1'b0, "R9 middle");
      probe(39'd7047, 1'b0, "R9 second start");
      probe(39'd9093, 1'b0, "R9 second last");
      probe(39'd9094, 1'b1, "R9 after split kept");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_zero();
      t_nogo();
      t_busywr();
      t_fillbusy();
      t_split();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #400000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule